// File: doc/BRIEF.md
# Two-Slot Conflict-Free Queue with Flush

This block is a first-in first-out queue that holds at most two words in two registers: a head slot, which always drives the read-data output, and a tail slot, which takes every new write. Each slot has its own valid flag. A writer sees `push_ready` whenever the tail slot is empty. A reader sees `pop_ready` whenever the head slot is valid. Each ready depends only on stored state, so a write and a read can both be taken in one cycle without either side looking at the other's request.

All updates in a cycle are applied in a fixed order: write, then read, then flush. A last promotion step follows them. If the tail ends up valid while the head is empty, the tail word moves into the head slot. As a result, a lone element is always held in the head slot. A flush empties both slots, and it overrides a write that arrives in the same cycle.

Top module: `cf_fifo2`

## Requirements
- R1: When `rst_n` is low at a clock edge, both slots become empty. After that edge `push_ready` is 1 and `pop_ready` is 0.
- R2: `push_ready` is 1 exactly when fewer than two words are held. A write offered while `push_ready` is 0 has no effect on the stored words.
- R3: `pop_ready` is 1 exactly when at least one word is held. While it is 1, `head_data` shows the oldest held word. That value holds steady until a read or a flush is taken.
- R4: A word written into an empty queue appears on `head_data`, with `pop_ready` at 1, on the cycle after the write.
- R5: A write and a read taken in the same cycle on a one-word queue leave exactly the new word, shown on `head_data`, with `push_ready` at 1.
- R6: A flush empties the queue by the next cycle. A write offered in the same cycle as the flush is lost.
- R7: Under any mix of writes, reads and flushes, words leave the queue in the order they were accepted, and none is lost or duplicated except by a flush.
- R8: Within one cycle, `push_ready` does not change with `pop_valid`, and `pop_ready` does not change with `push_valid`.
- R9: A read from a full queue promotes the second word to `head_data` on the next cycle, and `push_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Write request |
| push_data | input | DATA_W | Write data |
| push_ready | output | 1 | Tail slot free; a write is taken when this and `push_valid` are both 1 |
| pop_valid | input | 1 | Read request |
| pop_ready | output | 1 | Head slot holds a word; a read is taken when this and `pop_valid` are both 1 |
| head_data | output | DATA_W | Word in the head slot (the oldest held word) |
| flush | input | 1 | Synchronous clear of both slots; overrides a same-cycle write |

## Verification
A wrong valid flag appears at the ready outputs on the very next cycle. A tail marked valid without a valid head shows up as `push_ready` low while `pop_ready` is also low. A lost promotion shows up as `pop_ready` low one cycle after a write into an empty queue. A wrong data path, such as a promotion that copies stale tail data or a flush that lets the same-cycle write slip through, is seen at the next accepted read. There, `head_data` is compared against a reference queue that is updated on every handshake. A missed promotion also shows up when `head_data` no longer changes after a read from a full queue.

// File: rtl/cf_fifo2_pkg.sv
// Shared types for the two-slot queue.
// Assumes slot index 0 is the head and slot index 1 is the tail.
package cf_fifo2_pkg;

    localparam int unsigned NUM_SLOTS = 2;
    localparam int unsigned HEAD_IDX  = 0;
    localparam int unsigned TAIL_IDX  = 1;

    // Next-state controls produced by the sequencing logic.
    typedef struct packed {
        logic head_v_d;       // head valid after this cycle
        logic tail_v_d;       // tail valid after this cycle
        logic head_we;        // load head data register
        logic tail_we;        // load tail data register
        logic head_from_push; // promotion source is this cycle's write data
    } slot_ctl_t;

endpackage

// File: rtl/cf_fifo2_slot.sv
// One storage slot: a data register and its valid flag.
// The valid flag resets to 0; the data register has no reset because it
// is only ever read while its valid flag is set.
module cf_fifo2_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_d,
    input  logic              we,
    input  logic [DATA_W-1:0] data_d,
    output logic              valid_q,
    output logic [DATA_W-1:0] data_q
);

    // Valid flag: reset to empty, otherwise follow the sequenced value.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    // Data register: load on write enable only.
    always_ff @(posedge clk) begin
        if (we) data_q <= data_d;
    end

endmodule

// File: rtl/cf_fifo2_ctrl.sv
// Sequencing logic for the two-slot queue.
// Applies the write, then the read, then the flush, then the promotion of
// the tail into an empty head. Both readies come from stored state only,
// so the two ports never depend on each other within a cycle.
module cf_fifo2_ctrl
    import cf_fifo2_pkg::*;
(
    input  logic      head_v,
    input  logic      tail_v,
    input  logic      push_valid,
    input  logic      pop_valid,
    input  logic      flush,
    output logic      push_ready,
    output logic      pop_ready,
    output slot_ctl_t ctl
);

    logic enq_fire;
    logic deq_fire;
    logic head_after_ops;
    logic tail_after_ops;
    logic promote;

    // Port readiness from stored flags alone.
    always_comb begin
        push_ready = !tail_v;
        pop_ready  = head_v;
        enq_fire   = push_valid && push_ready;
        deq_fire   = pop_valid && pop_ready;
    end

    // Ordered update: write, read, flush, then the end-of-cycle promotion.
    always_comb begin
        tail_after_ops = (tail_v || enq_fire) && !flush;
        head_after_ops = (head_v && !deq_fire) && !flush;
        promote        = tail_after_ops && !head_after_ops;

        ctl.head_v_d       = head_after_ops || promote;
        ctl.tail_v_d       = tail_after_ops && !promote;
        ctl.tail_we        = enq_fire;
        ctl.head_we        = promote;
        ctl.head_from_push = enq_fire;
    end

endmodule

// File: rtl/cf_fifo2.sv
// Two-entry queue with conflict-free write/read ports and synchronous flush.
// Assumes a single clock and a synchronous active-low reset. The
// occupancy invariant (tail valid implies head valid) is kept by the
// promotion step in cf_fifo2_ctrl.
module cf_fifo2
    import cf_fifo2_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              pop_valid,
    output logic              pop_ready,
    output logic [DATA_W-1:0] head_data,
    input  logic              flush
);

    logic [NUM_SLOTS-1:0]             v_q;
    logic [NUM_SLOTS-1:0]             v_d;
    logic [NUM_SLOTS-1:0]             we;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] d_d;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] d_q;
    slot_ctl_t                        ctl;

    cf_fifo2_ctrl u_ctrl (
        .head_v     (v_q[HEAD_IDX]),
        .tail_v     (v_q[TAIL_IDX]),
        .push_valid (push_valid),
        .pop_valid  (pop_valid),
        .flush      (flush),
        .push_ready (push_ready),
        .pop_ready  (pop_ready),
        .ctl        (ctl)
    );

    // Route sequenced controls and data sources to each slot.
    always_comb begin
        v_d[HEAD_IDX] = ctl.head_v_d;
        v_d[TAIL_IDX] = ctl.tail_v_d;
        we[HEAD_IDX]  = ctl.head_we;
        we[TAIL_IDX]  = ctl.tail_we;
        d_d[HEAD_IDX] = ctl.head_from_push ? push_data : d_q[TAIL_IDX];
        d_d[TAIL_IDX] = push_data;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        cf_fifo2_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_d (v_d[i]),
            .we      (we[i]),
            .data_d  (d_d[i]),
            .valid_q (v_q[i]),
            .data_q  (d_q[i])
        );
    end

    assign head_data = d_q[HEAD_IDX];

    // R1: a reset edge leaves the queue empty.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (push_ready && !pop_ready));

    // R2: a full queue still shows a word at the head.
    a_r2_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        !push_ready |-> pop_ready);

    // R3: with no read and no flush, the head word stays put.
    a_r3_head_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ready && !pop_valid && !flush) |=> (pop_ready && $stable(head_data)));

    // R4: a write into an empty queue reaches the head one cycle later.
    a_r4_lone_in_head: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !pop_ready && !flush)
        |=> (pop_ready && head_data == $past(push_data)));

    // R6: a flush leaves the queue empty.
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (push_ready && !pop_ready));

    // R9: a read from a full queue frees the tail slot.
    a_r9_pop_full_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ready && pop_valid && !flush) |=> (push_ready && pop_ready));

endmodule

// File: tb/cf_fifo2_tb.sv
// Scoreboard bench: a monitor mirrors every handshake into a reference
// queue and compares read data; directed steps check the corner cases.
module cf_fifo2_tb;

    localparam int unsigned DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_valid = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic              push_ready;
    logic              pop_valid = 1'b0;
    logic              pop_ready;
    logic [DATA_W-1:0] head_data;
    logic              flush = 1'b0;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    logic [DATA_W-1:0] model_q[$];

    always #5 clk = ~clk;

    cf_fifo2 #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .head_data(head_data),
        .flush(flush)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then return to idle after the edge.
    task automatic step(input logic pv, input logic [DATA_W-1:0] pd,
                        input logic qv, input logic fl);
        @(negedge clk);
        push_valid = pv; push_data = pd; pop_valid = qv; flush = fl;
        @(posedge clk);
        #1;
        push_valid = 1'b0; pop_valid = 1'b0; flush = 1'b0;
    endtask

    // Monitor: mirror handshakes into the reference queue (write, read, flush).
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                check("R3 pop_ready", pop_ready, (model_q.size() != 0));
                check("R2 push_ready", push_ready, (model_q.size() < 2));
                if (pop_valid && pop_ready && model_q.size() != 0) begin
                    check("R7 order", head_data, model_q[0]);
                    void'(model_q.pop_front());
                end
                if (push_valid && push_ready) model_q.push_back(push_data);
                if (flush) model_q.delete();
            end else begin
                model_q.delete();
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 push_ready", push_ready, 1'b1);
        check("R1 pop_ready", pop_ready, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        step(1'b1, 16'h00A1, 1'b0, 1'b0);
        check("R4 pop_ready", pop_ready, 1'b1);
        check("R4 head", head_data, 16'h00A1);

        step(1'b1, 16'h00B2, 1'b0, 1'b0);
        check("R2 full", push_ready, 1'b0);
        step(1'b1, 16'h00C3, 1'b0, 1'b0);
        check("R2 ignored head", head_data, 16'h00A1);

        // R8: readiness does not follow the other port's request.
        @(negedge clk);
        #3;
        begin
            logic pr0, qr0;
            pr0 = push_ready; qr0 = pop_ready;
            pop_valid = 1'b1; push_valid = 1'b1; push_data = 16'h0EEE;
            #1;
            check("R8 push_ready", push_ready, pr0);
            check("R8 pop_ready", pop_ready, qr0);
            pop_valid = 1'b0; push_valid = 1'b0;
        end

        step(1'b0, '0, 1'b1, 1'b0);
        check("R9 head", head_data, 16'h00B2);
        check("R9 push_ready", push_ready, 1'b1);

        step(1'b1, 16'h00D4, 1'b1, 1'b0);
        check("R5 head", head_data, 16'h00D4);
        check("R5 push_ready", push_ready, 1'b1);
        check("R5 pop_ready", pop_ready, 1'b1);

        step(1'b1, 16'h00E5, 1'b0, 1'b1);
        check("R6 pop_ready", pop_ready, 1'b0);
        check("R6 push_ready", push_ready, 1'b1);
        step(1'b0, '0, 1'b0, 1'b0);
        check("R6 write lost", pop_ready, 1'b0);

        step(1'b1, 16'h00F6, 1'b0, 1'b0);
        check("R4 after flush", head_data, 16'h00F6);
        step(1'b0, '0, 1'b1, 1'b0);
        check("R3 drained", pop_ready, 1'b0);

        // R7: random traffic against the reference queue.
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 3) != 0, DATA_W'($urandom),
                 ($urandom % 2) != 0, ($urandom % 40) == 0);
        end

        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule